// File: doc/BRIEF.md
# Charge Current Reference Sequencer

This block turns a programmed full-scale charge-current code into the setpoint code that feeds the current-reference DAC of a battery charger. Each time charging becomes permitted, the setpoint climbs to its target in eight equal increments. Each increment is held for a fixed number of clock cycles, so the converter starts without overshoot.

The target is the programmed code. While the battery-short comparator reports a deeply discharged pack, the target drops to one eighth of that code. Charging is withheld while the enable is low, during a gas-gauge learn discharge, under adapter overvoltage, after an input overpower latch, and during a thermal shutdown. The thermal shutdown is a hysteretic condition built from two comparator flags: a hot flag for the upper trip point and a cool flag for the lower release point. A charging-active flag travels with the setpoint.

The analog regulation loop and input-current limiting sit outside this block. Its only outputs are the registered setpoint and the active flag.

Top module: `chg_iref_seq`

## Requirements
- R1: While reset is held, and on every cycle after release until charging is permitted, `iset_code` is 0 and `chg_active` is 0.
- R2: On the first rising clock edge at which charging is permitted, `chg_active` becomes 1 and `iset_code` becomes floor(T/8). T is the current target.
- R3: The ramp stage k runs from 1 to 8. Each stage lasts STEP_CYC clock edges, and `iset_code` equals floor(T*k/8) during stage k. After stage 8 is reached, the setpoint holds at T for as long as charging stays permitted.
- R4: The target T is floor(`full_code`/8) while `bat_short` is 1 and `full_code` while it is 0.
- R5: A change of `bat_short` or `full_code` while charging appears on `iset_code` at the next edge, at the same ramp stage. The ramp does not restart.
- R6: When `chg_en` is 0 at an edge, that edge drives `iset_code` to 0 and `chg_active` to 0. The next permitted edge restarts the ramp at stage 1.
- R7: `learn`, `ac_ovp` and `opwr_latch` each withhold charging exactly as a low `chg_en` does, for as long as they are 1.
- R8: `tj_hot` = 1 enters thermal shutdown, which withholds charging. The shutdown persists after `tj_hot` falls and ends only at an edge where `tj_cool` = 1 and `tj_hot` = 0. A `tj_cool` pulse outside shutdown has no effect on the setpoint.
- R9: When `tj_hot` and `tj_cool` are both 1, the hot flag wins and charging is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_en | input | 1 | Charge enable request |
| full_code | input | CODE_W | Programmed full-scale charge-current code |
| bat_short | input | 1 | Battery below the short threshold (pre-charge) |
| learn | input | 1 | Learn discharge in progress |
| ac_ovp | input | 1 | Adapter overvoltage present |
| opwr_latch | input | 1 | Input overpower fault latched |
| tj_hot | input | 1 | Die temperature above the upper trip point |
| tj_cool | input | 1 | Die temperature below the lower release point |
| iset_code | output | CODE_W | Setpoint code for the current DAC |
| chg_active | output | 1 | Charging permitted and setpoint valid |

## Verification
The bench builds the block with CODE_W = 10 and STEP_CYC = 4, keeping STEP_LG = 3 and PRE_SH = 3. With these values a full eight-stage ramp takes 32 cycles. Many restarts therefore fit into a short run: after enable drops, after each inhibit source, after thermal release, and with the pre-charge target active from the first stage. An odd full-scale code of 1023 is used, so the floor rounding of every stage and of the one-eighth target is observable, along with mid-ramp target changes.

// File: rtl/chg_iref_pkg.sv
package chg_iref_pkg;

  // Snapshot of every condition that can withhold charging.
  typedef struct packed {
    logic learn;
    logic ovp;
    logic opwr;
    logic hot;
  } chg_block_t;

  function automatic logic any_block(input chg_block_t b);
    return b.learn | b.ovp | b.opwr | b.hot;
  endfunction

endpackage

// File: rtl/chg_gate.sv
module chg_gate
  import chg_iref_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chg_en,
  input  logic learn,
  input  logic ac_ovp,
  input  logic opwr_latch,
  input  logic tj_hot,
  input  logic tj_cool,
  output logic permit
);

  logic       therm_q;
  logic       therm_d;
  chg_block_t blk;

  // Hysteresis: set by the hot flag, cleared only by the cool flag.
  always_comb begin
    therm_d = therm_q;
    if (tj_hot)       therm_d = 1'b1;
    else if (tj_cool) therm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) therm_q <= 1'b0;
    else        therm_q <= therm_d;
  end

  always_comb begin
    blk.learn = learn;
    blk.ovp   = ac_ovp;
    blk.opwr  = opwr_latch;
    blk.hot   = therm_d;
    permit    = chg_en & ~any_block(blk);
  end

endmodule

// File: rtl/chg_ramp.sv
module chg_ramp #(
  parameter int STEP_LG  = 3,
  parameter int STEP_CYC = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             permit,
  output logic [STEP_LG:0] stage_nx
);

  localparam int NSTEPS = 1 << STEP_LG;
  localparam int TMR_W  = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [STEP_LG:0] stage_q;
  logic             at_top;
  logic             step_done;

  assign at_top = (stage_q == (STEP_LG+1)'(NSTEPS));

  generate
    if (STEP_CYC > 1) begin : g_tmr
      logic [TMR_W-1:0] tmr_q;
      logic [TMR_W-1:0] tmr_d;
      logic             tmr_en;

      assign step_done = (tmr_q == TMR_W'(STEP_CYC - 1));
      assign tmr_en    = permit & (stage_q != '0) & ~at_top;

      always_comb begin
        tmr_d = '0;
        if (tmr_en && !step_done) tmr_d = tmr_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
      end
    end else begin : g_notmr
      assign step_done = 1'b1;
    end
  endgenerate

  always_comb begin
    stage_nx = stage_q;
    if (!permit)                   stage_nx = '0;
    else if (stage_q == '0)        stage_nx = (STEP_LG+1)'(1);
    else if (!at_top && step_done) stage_nx = stage_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_nx;
  end

endmodule

// File: rtl/chg_scale.sv
module chg_scale #(
  parameter int CODE_W  = 10,
  parameter int STEP_LG = 3,
  parameter int PRE_SH  = 3
) (
  input  logic [CODE_W-1:0] full_code,
  input  logic              bat_short,
  input  logic [STEP_LG:0]  stage,
  output logic [CODE_W-1:0] level
);

  localparam int PW = CODE_W + STEP_LG + 1;

  logic [CODE_W-1:0] target;
  logic [PW-1:0]     prod;

  always_comb begin
    target = bat_short ? (full_code >> PRE_SH) : full_code;
    prod   = PW'(target) * PW'(stage);
    level  = CODE_W'(prod >> STEP_LG);
  end

endmodule

// File: rtl/chg_iref_seq.sv
module chg_iref_seq #(
  parameter int CODE_W   = 10,
  parameter int STEP_LG  = 3,
  parameter int STEP_CYC = 100000,
  parameter int PRE_SH   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chg_en,
  input  logic [CODE_W-1:0] full_code,
  input  logic              bat_short,
  input  logic              learn,
  input  logic              ac_ovp,
  input  logic              opwr_latch,
  input  logic              tj_hot,
  input  logic              tj_cool,
  output logic [CODE_W-1:0] iset_code,
  output logic              chg_active
);

  logic              permit;
  logic [STEP_LG:0]  stage_nx;
  logic [CODE_W-1:0] level;
  logic [CODE_W-1:0] iset_d;
  logic [CODE_W-1:0] iset_q;
  logic              act_q;

  chg_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .chg_en     (chg_en),
    .learn      (learn),
    .ac_ovp     (ac_ovp),
    .opwr_latch (opwr_latch),
    .tj_hot     (tj_hot),
    .tj_cool    (tj_cool),
    .permit     (permit)
  );

  chg_ramp #(.STEP_LG(STEP_LG), .STEP_CYC(STEP_CYC)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .permit   (permit),
    .stage_nx (stage_nx)
  );

  chg_scale #(.CODE_W(CODE_W), .STEP_LG(STEP_LG), .PRE_SH(PRE_SH)) u_scale (
    .full_code (full_code),
    .bat_short (bat_short),
    .stage     (stage_nx),
    .level     (level)
  );

  assign iset_d = permit ? level : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iset_q <= '0;
      act_q  <= 1'b0;
    end else begin
      iset_q <= iset_d;
      act_q  <= permit;
    end
  end

  assign iset_code  = iset_q;
  assign chg_active = act_q;

endmodule

// File: rtl/chg_iref_seq_chk.sv
module chg_iref_seq_chk #(
  parameter int CODE_W  = 10,
  parameter int STEP_LG = 3,
  parameter int PRE_SH  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chg_en,
  input logic [CODE_W-1:0] full_code,
  input logic              bat_short,
  input logic              learn,
  input logic              ac_ovp,
  input logic              opwr_latch,
  input logic              tj_hot,
  input logic [CODE_W-1:0] iset_code,
  input logic              chg_active
);

  // R7
  block_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (learn || ac_ovp || opwr_latch) |=> !chg_active);

  // R8
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tj_hot |=> (!chg_active && iset_code == '0));

  // R6
  en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_en |=> (!chg_active && iset_code == '0));

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_active |-> iset_code == '0);

  // R2
  first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_active) |-> iset_code == CODE_W'(($past(bat_short) ?
      ($past(full_code) >> PRE_SH) : $past(full_code)) >> STEP_LG));

  // R3
  ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_active |-> iset_code <= $past(full_code));

endmodule

bind chg_iref_seq chg_iref_seq_chk #(
  .CODE_W(CODE_W), .STEP_LG(STEP_LG), .PRE_SH(PRE_SH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chg_en     (chg_en),
  .full_code  (full_code),
  .bat_short  (bat_short),
  .learn      (learn),
  .ac_ovp     (ac_ovp),
  .opwr_latch (opwr_latch),
  .tj_hot     (tj_hot),
  .iset_code  (iset_code),
  .chg_active (chg_active)
);

// File: tb/chg_iref_seq_tb_top.sv
`timescale 1ns/1ps
module chg_iref_seq_tb_top;

  localparam int CODE_W   = 10;
  localparam int STEP_LG  = 3;
  localparam int STEP_CYC = 4;
  localparam int PRE_SH   = 3;

  typedef struct {
    int    code;
    bit    act;
    string tag;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic              chg_en;
  logic [CODE_W-1:0] full_code;
  logic              bat_short, learn, ac_ovp, opwr_latch, tj_hot, tj_cool;
  logic [CODE_W-1:0] iset_code;
  logic              chg_active;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  bit   done  = 0;
  bit   m_therm = 0;
  int   m_on    = 0;

  chg_iref_seq #(.CODE_W(CODE_W), .STEP_LG(STEP_LG), .STEP_CYC(STEP_CYC),
                 .PRE_SH(PRE_SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .full_code(full_code),
    .bat_short(bat_short), .learn(learn), .ac_ovp(ac_ovp),
    .opwr_latch(opwr_latch), .tj_hot(tj_hot), .tj_cool(tj_cool),
    .iset_code(iset_code), .chg_active(chg_active)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Driver: predicts the outputs after the coming edge from the requirements.
  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      bit   ok;
      int   k, tgt;
      m_therm = tj_hot | (m_therm & ~tj_cool);
      ok = chg_en & ~learn & ~ac_ovp & ~opwr_latch & ~m_therm;
      e.code = 0;
      if (ok) begin
        k = m_on / STEP_CYC + 1;
        if (k > 8) k = 8;
        tgt = bat_short ? (int'(full_code) / 8) : int'(full_code);
        e.code = (tgt * k) / 8;
        m_on++;
      end else begin
        m_on = 0;
      end
      e.act = ok;
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
    end
  endtask

  // Monitor: compares after each edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (int'(iset_code) != e.code || chg_active != e.act) begin
        bad++;
        $display("FAIL %s: iset_code=%0d chg_active=%0b expected %0d/%0b",
                 e.tag, iset_code, chg_active, e.code, e.act);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; chg_en = 0; full_code = 10'd800; bat_short = 0;
    learn = 0; ac_ovp = 0; opwr_latch = 0; tj_hot = 0; tj_cool = 0;
    repeat (3) @(negedge clk);
    total++;
    if (iset_code != 0 || chg_active != 0) begin
      bad++;
      $display("FAIL R1: iset_code=%0d chg_active=%0b expected 0/0",
               iset_code, chg_active);
    end
    rst_n = 1;
    run(3, "R1");
    chg_en = 1;
    run(40, "R2 R3 ramp");
    full_code = 10'd640;
    run(4, "R5 code change");
    bat_short = 1;
    run(4, "R4 short on");
    bat_short = 0;
    run(4, "R4 short off");
    chg_en = 0;
    run(3, "R6 disable");
    chg_en = 1; bat_short = 1;
    run(10, "R6 R4 restart");
    bat_short = 0;
    run(26, "R5 mid-ramp");
    learn = 1;  run(3, "R7 learn");  learn = 0;  run(10, "R7 resume");
    ac_ovp = 1; run(3, "R7 ovp");    ac_ovp = 0; run(10, "R7 resume");
    opwr_latch = 1; run(3, "R7 opwr"); opwr_latch = 0; run(36, "R7 resume");
    tj_cool = 1; run(3, "R8 cool alone"); tj_cool = 0;
    tj_hot = 1;  run(2, "R8 hot");        tj_hot = 0;
    run(5, "R8 hold");
    tj_cool = 1; run(2, "R8 release");    tj_cool = 0;
    run(12, "R8 resume");
    tj_hot = 1; tj_cool = 1; run(2, "R9 both"); tj_hot = 0;
    run(2, "R8 cool release"); tj_cool = 0;
    full_code = 10'd1023;
    run(36, "R3 odd ramp");
    chg_en = 0; run(1, "R6 off"); chg_en = 1; bat_short = 1;
    run(36, "R4 odd precharge");
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule